// File: doc/BRIEF.md
# Interrupt polarity inverter bank

This block sits between a set of shared interrupt sources and an interrupt controller. That controller only understands active-high levels and rising edges. Each shared line goes through an exclusive-OR with its own configuration bit. A source that signals with a low level or a falling edge therefore reaches the controller as a high level or a rising edge. The block does no detection, latching, masking or routing; the downstream controller keeps all of those jobs.

Software programs the configuration bits through a small register port that moves whole 32-bit words. The words are indexed by global interrupt ID, and shared lines start at ID 32. The first word covers the private and software-generated IDs, which have no inverter, so that word is reserved: it reads as zero and ignores writes. Shared line `s` is controlled by bit `s % 32` of the word at byte offset `((s + 32) / 32) * 4`. To change a single bit, software reads the word, modifies it and writes it back.

Top module: `pol_inv_bank`

## Requirements
- R1: After reset every configuration bit is 0, so each output equals its input and every register word reads as zero.
- R2: A shared line whose configuration bit is 0 leaves the block unchanged (`irq_out[s] == irq_in[s]`).
- R3: A shared line whose configuration bit is 1 leaves the block inverted (`irq_out[s] == !irq_in[s]`). A low-level or falling-edge source thus appears as high-level or rising-edge.
- R4: Shared line `s` (global ID `s+32`) is controlled by bit `s % 32` of word index `s/32 + 1`. Word index `w` sits at byte offset `4*w` on `bus_addr`.
- R5: A read of an implemented word returns exactly the value last written to it. `bus_rdata` carries the value in the cycle after the clock edge that samples `bus_rd`, and holds it until the next read.
- R6: Word index 0 (byte offsets 0x00 to 0x03, IDs 0 to 31) reads as zero, and writes to it change no configuration bit.
- R7: Word indices above `(NUM_SPI+31)/32` read as zero, and writes to them change no configuration bit.
- R8: The path from `irq_in` to `irq_out` is purely combinational: an input change shows on the output with no clock edge.
- R9: A write is sampled on a rising clock edge. The outputs reflect the new configuration right after that edge and not before it.
- R10: `bus_addr[1:0]` are ignored. Any byte offset within a word selects that whole word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | NUM_SPI | Raw shared interrupt lines |
| irq_out | output | NUM_SPI | Normalised lines to the controller |

## Verification
The inversion path is driven with random input vectors under random configuration words. This shows that each line follows only its own bit and its own word, and not a neighbouring bit or word. Directed patterns cover the remaining cases. All-ones and alternating words check the bit-to-line mapping. Writes to the reserved word and to out-of-range words must leave every output and readback untouched. Input toggles with no clock edge separate the combinational path from a registered one. Sampling just before and just after a write's edge pins down the cycle in which a new setting becomes visible.

// File: rtl/pol_inv_pkg.sv
package pol_inv_pkg;
    localparam int WORD_W       = 32;
    localparam int PRIVATE_IDS  = 32;
    localparam int BYTE_LSBS    = 2;

    function automatic int words_for(input int lines);
        return (lines + WORD_W - 1) / WORD_W;
    endfunction
endpackage

// File: rtl/pol_cfg_regs.sv
module pol_cfg_regs
    import pol_inv_pkg::*;
#(
    parameter int NUM_SPI = 96,
    parameter int ADDR_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic [NUM_SPI-1:0]   cfg
);
    localparam int NUM_WORDS = words_for(NUM_SPI);
    localparam int WIDX_W    = ADDR_W - BYTE_LSBS;

    typedef struct packed {
        logic [NUM_SPI-1:0] cfg;
        logic [WORD_W-1:0]  rdata;
    } regs_t;

    regs_t              st_d, st_q;
    logic [WIDX_W-1:0]  widx;

    assign widx = bus_addr[ADDR_W-1:BYTE_LSBS];

    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            for (int k = 0; k < NUM_WORDS; k++) begin
                if (widx == WIDX_W'(k + 1)) begin
                    for (int b = 0; b < WORD_W; b++) begin
                        if (k * WORD_W + b < NUM_SPI)
                            st_d.cfg[k * WORD_W + b] = bus_wdata[b];
                    end
                end
            end
        end
        if (bus_rd) begin
            st_d.rdata = '0;
            for (int k = 0; k < NUM_WORDS; k++) begin
                if (widx == WIDX_W'(k + 1)) begin
                    for (int b = 0; b < WORD_W; b++) begin
                        if (k * WORD_W + b < NUM_SPI)
                            st_d.rdata[b] = st_q.cfg[k * WORD_W + b];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg       = st_q.cfg;
    assign bus_rdata = st_q.rdata;

    // Configuration is zero in the first cycle after reset
    assert_cfg_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (cfg == '0 && bus_rdata == '0));

    // Without a write the configuration never moves
    assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_wr) |-> $stable(cfg));

    // Reserved word: writes inert, reads zero
    assert_rsvd_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_wr && bus_addr[ADDR_W-1:BYTE_LSBS] == '0) |-> $stable(cfg));
    assert_rsvd_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && bus_addr[ADDR_W-1:BYTE_LSBS] == '0) |-> bus_rdata == '0);

    // Out-of-range words: writes inert, reads zero
    assert_oor_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_wr && int'(bus_addr[ADDR_W-1:BYTE_LSBS]) > NUM_WORDS) |-> $stable(cfg));
    assert_oor_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && int'(bus_addr[ADDR_W-1:BYTE_LSBS]) > NUM_WORDS) |-> bus_rdata == '0);

    // Read data changes only on a read
    assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> $stable(bus_rdata));
endmodule

// File: rtl/pol_xor_stage.sv
module pol_xor_stage #(
    parameter int NUM_SPI = 96
) (
    input  logic [NUM_SPI-1:0] line_in,
    input  logic [NUM_SPI-1:0] invert,
    output logic [NUM_SPI-1:0] line_out
);
    for (genvar i = 0; i < NUM_SPI; i++) begin : g_line
        assign line_out[i] = line_in[i] ^ invert[i];
    end
endmodule

// File: rtl/pol_inv_bank.sv
module pol_inv_bank
    import pol_inv_pkg::*;
#(
    parameter int NUM_SPI = 96,
    parameter int ADDR_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_SPI-1:0]   irq_in,
    output logic [NUM_SPI-1:0]   irq_out
);
    logic [NUM_SPI-1:0] cfg;

    pol_cfg_regs #(.NUM_SPI(NUM_SPI), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg       (cfg)
    );

    pol_xor_stage #(.NUM_SPI(NUM_SPI)) u_xor (
        .line_in  (irq_in),
        .invert   (cfg),
        .line_out (irq_out)
    );

    // With no write in the last cycle, a stable input gives a stable output
    assert_out_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bus_wr) && $stable(irq_in)) |-> $stable(irq_out));
endmodule

// File: tb/pol_inv_bank_bench.sv
module pol_inv_bank_bench;
    localparam int NUM_SPI = 96;
    localparam int ADDR_W  = 8;
    localparam int NWORDS  = (NUM_SPI + 31) / 32;

    logic clk = 0, rst_n = 0;
    logic bus_wr = 0, bus_rd = 0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NUM_SPI-1:0] irq_in = '0;
    logic [NUM_SPI-1:0] irq_out;

    logic [NUM_SPI-1:0] model = '0;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pol_inv_bank #(.NUM_SPI(NUM_SPI), .ADDR_W(ADDR_W)) u_pol_inv_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    function automatic logic [31:0] exp_word(input int w);
        logic [31:0] r = '0;
        if (w >= 1 && w <= NWORDS)
            for (int b = 0; b < 32; b++)
                if ((w - 1) * 32 + b < NUM_SPI) r[b] = model[(w - 1) * 32 + b];
        return r;
    endfunction

    function automatic logic [NUM_SPI-1:0] exp_out(input logic [NUM_SPI-1:0] v);
        return v ^ model;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic check_out(input string tag);
        check(irq_out === exp_out(irq_in), tag, 128'(irq_out), 128'(exp_out(irq_in)));
    endtask

    task automatic model_write(input int w, input logic [31:0] d);
        if (w >= 1 && w <= NWORDS)
            for (int b = 0; b < 32; b++)
                if ((w - 1) * 32 + b < NUM_SPI) model[(w - 1) * 32 + b] = d[b];
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
        model_write(int'(a[ADDR_W-1:2]), d);
    endtask

    task automatic bus_read_check(input logic [ADDR_W-1:0] a, input string tag);
        logic [31:0] e;
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        e = exp_word(int'(a[ADDR_W-1:2]));
        @(negedge clk);
        bus_rd = 0;
        check(bus_rdata === e, tag, 128'(bus_rdata), 128'(e));
    endtask

    task automatic set_in(input logic [NUM_SPI-1:0] v);
        irq_in = v;
        #0.5;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        set_in({3{32'hA5C3_0F71}});
        check_out("R1 reset passthrough");
        for (int w = 0; w <= NWORDS; w++) bus_read_check(ADDR_W'(w * 4), "R1 reset readback");

        // R2: all clear passes through
        set_in({NUM_SPI{1'b1}});
        check_out("R2 clear passes ones");

        // R3/R4: invert word 1 fully -> lines 0..31 inverted
        bus_write(8'h04, 32'hFFFF_FFFF);
        set_in('0);
        check(irq_out === {64'h0, 32'hFFFF_FFFF}, "R3 word1 inverts lines 0-31",
              128'(irq_out), 128'({64'h0, 32'hFFFF_FFFF}));
        // R4: alternating pattern in word 3 -> lines 64..95
        bus_write(8'h0C, 32'h5555_AAAA);
        set_in('0);
        check(irq_out[95:64] === 32'h5555_AAAA, "R4 word3 maps lines 64-95",
              128'(irq_out[95:64]), 128'(32'h5555_AAAA));
        check(irq_out[63:32] === 32'h0, "R4 word2 untouched",
              128'(irq_out[63:32]), 128'(0));
        bus_read_check(8'h0C, "R5 readback word3");
        bus_read_check(8'h04, "R5 readback word1");

        // R6: reserved word
        bus_write(8'h00, 32'hFFFF_FFFF);
        set_in({3{32'h1234_5678}});
        check_out("R6 reserved write inert");
        bus_read_check(8'h00, "R6 reserved reads zero");

        // R7: out-of-range words
        bus_write(8'h10, 32'hDEAD_BEEF);
        bus_write(8'hFC, 32'hFFFF_FFFF);
        check_out("R7 out-of-range write inert");
        bus_read_check(8'h10, "R7 out-of-range reads zero");
        bus_read_check(8'hFC, "R7 top word reads zero");
        for (int w = 1; w <= NWORDS; w++) bus_read_check(ADDR_W'(w * 4), "R7 implemented words intact");

        // R10: low address bits ignored
        bus_write(8'h0B, 32'h0F0F_1234);
        bus_read_check(8'h09, "R10 byte offset selects word2");
        check_out("R10 outputs after offset write");

        // R8: combinational path, mid-cycle toggles
        @(negedge clk);
        #0.5 irq_in = {3{32'hCAFE_F00D}};
        #0.5 check_out("R8 no-clock response a");
        irq_in = ~irq_in;
        #0.5 check_out("R8 no-clock response b");

        // R9: timing of a new setting
        @(negedge clk);
        bus_wr = 1; bus_addr = 8'h08; bus_wdata = 32'hFFFF_0000;
        #1 check_out("R9 old setting before edge");
        @(negedge clk);
        bus_wr = 0;
        model_write(2, 32'hFFFF_0000);
        check_out("R9 new setting after edge");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [ADDR_W-1:0] a;
            a = ($urandom % 4 == 0) ? ADDR_W'($urandom) : ADDR_W'($urandom % ((NWORDS + 1) * 4));
            set_in({$urandom, $urandom, $urandom});
            if ($urandom % 2) bus_write(a, $urandom);
            else              bus_read_check(a, "R5 random readback");
            set_in({$urandom, $urandom, $urandom});
            check_out("R2 R3 random outputs");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule